// File: doc/BRIEF.md
# Character Overlay Vertical Timing Generator

This block produces the vertical raster position for a character overlay. It counts video lines from the rising edge of vertical sync, using one `hs_tick` pulse per line. Once the count reaches a programmable start line, it steps through the dot rows of each character row. The outputs are a vertical-active flag, the character row index and the dot row index within that row. A font lookup stage downstream combines these with horizontal timing to pick font pixels.

Each dot row can be stretched over one, two or three video lines to enlarge the glyphs vertically. The top character row has its own stretch setting. All rows below it share a second setting. The display is twelve rows deep, or ten rows deep when the short mode is selected.

All settings pass through a shadow register that loads only on the vertical sync edge, so one frame is always drawn with a single set of values.

Top module: `osd_vtiming`

## Requirements
- R1: After reset, `v_active` is 0 and both indices are 0 until the first rising edge of `vsync_in`, even if `hs_tick` pulses arrive.
- R2: Line k of a frame is the line after k `hs_tick` pulses since the `vsync_in` rising edge. Line 0 is the line before any pulse. `v_active` is first 1 on line 2*`start_pos`.
- R3: While active, `dot_row` counts 0 to 17. After dot row 17, `char_row` increments and `dot_row` returns to 0.
- R4: A size code gives the number of lines per dot row: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 3, and 2'b11 gives 1.
- R5: Character row 0 uses `size_first`. Every later row uses `size_rest`.
- R6: With `ten_rows`=0 the frame shows rows 0 to 11. With `ten_rows`=1 it shows rows 0 to 9. `v_active` falls on the line after the last repeat of dot row 17 of the last row, and stays low until the next vsync edge.
- R7: Whenever `v_active` is 0, `char_row` and `dot_row` are 0.
- R8: Settings are captured on the `vsync_in` rising edge. Changing the setting inputs mid-frame has no effect on the current frame.
- R9: A `vsync_in` rising edge restarts the frame at line 0, even in the middle of the display.
- R10: The outputs change only on an `hs_tick` pulse or a vsync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; all settings become zero |
| vsync_in | input | 1 | Vertical sync level; its rising edge starts a frame |
| hs_tick | input | 1 | One-cycle pulse per video line |
| start_pos | input | 6 | Start position in units of 2 lines |
| size_first | input | 2 | Line repeat code for character row 0 |
| size_rest | input | 2 | Line repeat code for rows 1 and up |
| ten_rows | input | 1 | 1 selects 10 character rows, 0 selects 12 |
| v_active | output | 1 | Current line lies inside the character area |
| char_row | output | 4 | Character row index |
| dot_row | output | 5 | Dot row index within the character |

## Verification
The bench builds the block with its default parameters: 18 dot rows, 12 or 10 rows, and an 8-bit line counter. With these values the largest start line (126) and the longest display (648 lines, with 3 lines per dot row) both fit inside a single short frame. Every stretch code and both row counts can therefore be driven to the end of a frame, where `v_active` falls. A line-by-line reference computed from the requirements is compared on every line. Directed runs cover mid-frame setting changes and a restart during the display.

// File: rtl/osdv_pkg.sv
package osdv_pkg;
  localparam int VP_W   = 6;
  localparam int SIZE_W = 2;

  typedef struct packed {
    logic [VP_W-1:0]   vp;
    logic [SIZE_W-1:0] size_first;
    logic [SIZE_W-1:0] size_rest;
    logic              ten_rows;
  } vcfg_t;

  // lines spent on one dot row for a size code
  function automatic logic [1:0] repeat_count(input logic [SIZE_W-1:0] code);
    case (code)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  // first active line for a start position (2-line steps)
  function automatic logic [VP_W:0] start_line(input logic [VP_W-1:0] vp);
    return {vp, 1'b0};
  endfunction
endpackage

// File: rtl/osdv_cfg_shadow.sv
module osdv_cfg_shadow
  import osdv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  vcfg_t cfg_in,
  output vcfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (load)  cfg_q <= cfg_in;
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/osdv_line_count.sv
module osdv_line_count
  import osdv_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            tick,
  input  logic [VP_W-1:0] vp,
  output logic            start_reached
);
  logic [LINE_W-1:0] cnt_q;
  logic              at_max;

  assign at_max        = &cnt_q;
  assign start_reached = cnt_q >= LINE_W'(start_line(vp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (tick && !at_max)   cnt_q <= cnt_q + 1'b1;
  end

  // R9
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
  // R2
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_reached && !clear) |=> start_reached);
endmodule

// File: rtl/osdv_raster.sv
module osdv_raster
  import osdv_pkg::*;
#(
  parameter int DOT_ROWS   = 18,
  parameter int ROWS_FULL  = 12,
  parameter int ROWS_SHORT = 10,
  localparam int DOT_W = $clog2(DOT_ROWS),
  localparam int ROW_W = $clog2(ROWS_FULL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic             start_reached,
  input  vcfg_t            cfg,
  output logic             v_active,
  output logic [ROW_W-1:0] char_row,
  output logic [DOT_W-1:0] dot_row
);
  localparam logic [DOT_W-1:0] DOT_LAST  = DOT_W'(DOT_ROWS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS_FULL - 1);
  localparam logic [ROW_W-1:0] ROW_LAST_S = ROW_W'(ROWS_SHORT - 1);

  logic             done_q;
  logic [1:0]       rep_q;
  logic [1:0]       rep_lim;
  logic [ROW_W-1:0] last_row;
  logic             step, rep_last, dot_wrap, frame_end;

  assign rep_lim   = repeat_count((char_row == '0) ? cfg.size_first : cfg.size_rest);
  assign last_row  = cfg.ten_rows ? ROW_LAST_S : ROW_LAST;
  assign v_active  = start_reached && !done_q;
  assign step      = tick && v_active;
  assign rep_last  = (rep_q == rep_lim - 2'd1);
  assign dot_wrap  = rep_last && (dot_row == DOT_LAST);
  assign frame_end = dot_wrap && (char_row == last_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1; rep_q <= '0; dot_row <= '0; char_row <= '0;
    end else if (restart) begin
      done_q <= 1'b0; rep_q <= '0; dot_row <= '0; char_row <= '0;
    end else if (step) begin
      if (!rep_last) begin
        rep_q <= rep_q + 2'd1;
      end else begin
        rep_q <= '0;
        if (!dot_wrap) begin
          dot_row <= dot_row + 1'b1;
        end else begin
          dot_row <= '0;
          if (frame_end) begin
            done_q   <= 1'b1;
            char_row <= '0;
          end else begin
            char_row <= char_row + 1'b1;
          end
        end
      end
    end
  end

  // R3
  dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_row <= DOT_LAST);
  // R6
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart) |=> (char_row <= last_row));
  // R4
  rep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_active |-> (rep_q < rep_lim));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_active |-> (char_row == '0 && dot_row == '0));
  // R6
  frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && frame_end && !restart) |=> !v_active);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> ($stable(dot_row) && $stable(char_row)));
endmodule

// File: rtl/osd_vtiming.sv
module osd_vtiming
  import osdv_pkg::*;
#(
  parameter int DOT_ROWS   = 18,
  parameter int ROWS_FULL  = 12,
  parameter int ROWS_SHORT = 10,
  parameter int LINE_W     = 8,
  localparam int DOT_W = $clog2(DOT_ROWS),
  localparam int ROW_W = $clog2(ROWS_FULL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              hs_tick,
  input  logic [VP_W-1:0]   start_pos,
  input  logic [SIZE_W-1:0] size_first,
  input  logic [SIZE_W-1:0] size_rest,
  input  logic              ten_rows,
  output logic              v_active,
  output logic [ROW_W-1:0]  char_row,
  output logic [DOT_W-1:0]  dot_row
);
  logic  vs_q;
  logic  vs_edge;
  logic  start_reached;
  vcfg_t cfg_in, cfg_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync_in;
  end
  assign vs_edge = vsync_in && !vs_q;

  assign cfg_in = '{vp: start_pos, size_first: size_first,
                    size_rest: size_rest, ten_rows: ten_rows};

  osdv_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(vs_edge), .cfg_in(cfg_in), .cfg_q(cfg_live)
  );

  osdv_line_count #(.LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .clear(vs_edge), .tick(hs_tick),
    .vp(cfg_live.vp), .start_reached(start_reached)
  );

  osdv_raster #(.DOT_ROWS(DOT_ROWS), .ROWS_FULL(ROWS_FULL),
                .ROWS_SHORT(ROWS_SHORT)) u_raster (
    .clk(clk), .rst_n(rst_n), .restart(vs_edge), .tick(hs_tick),
    .start_reached(start_reached), .cfg(cfg_live),
    .v_active(v_active), .char_row(char_row), .dot_row(dot_row)
  );

  // R9
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> (char_row == '0 && dot_row == '0));
endmodule

// File: tb/osd_vtiming_tb.sv
module osd_vtiming_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync_in = 1'b0;
  logic       hs_tick = 1'b0;
  logic [5:0] start_pos = '0;
  logic [1:0] size_first = '0;
  logic [1:0] size_rest = '0;
  logic       ten_rows = 1'b0;
  logic       v_active;
  logic [3:0] char_row;
  logic [4:0] dot_row;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  osd_vtiming dut_i (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hs_tick(hs_tick),
    .start_pos(start_pos), .size_first(size_first), .size_rest(size_rest),
    .ten_rows(ten_rows), .v_active(v_active), .char_row(char_row),
    .dot_row(dot_row)
  );

  // {vp, size_first, size_rest, ten_rows}
  localparam logic [10:0] VEC [6] = '{
    {6'd0,  2'b00, 2'b00, 1'b0},
    {6'd3,  2'b01, 2'b00, 1'b0},
    {6'd5,  2'b10, 2'b01, 1'b1},
    {6'd63, 2'b11, 2'b10, 1'b0},
    {6'd1,  2'b00, 2'b11, 1'b1},
    {6'd2,  2'b10, 2'b10, 1'b1}
  };

  function automatic int reps(input logic [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 3;
    return 1;
  endfunction

  // expected {active, row, dot} for line k
  function automatic logic [9:0] model(input int k, input logic [10:0] v);
    int s, o, rf, rr, nrow, r;
    s = 2 * int'(v[10:5]);
    rf = reps(v[4:3]); rr = reps(v[2:1]);
    nrow = v[0] ? 10 : 12;
    o = k - s;
    if (o < 0) return '0;
    if (o < 18 * rf) return {1'b1, 4'd0, 5'(o / rf)};
    o = o - 18 * rf;
    r = 1 + o / (18 * rr);
    if (r >= nrow) return '0;
    return {1'b1, 4'(r), 5'((o % (18 * rr)) / rr)};
  endfunction

  function automatic int frame_len(input logic [10:0] v);
    return 2 * int'(v[10:5]) + 18 * reps(v[4:3]) +
           18 * reps(v[2:1]) * ((v[0] ? 10 : 12) - 1);
  endfunction

  task automatic chk(input string tag, input logic [9:0] exp);
    logic [9:0] got;
    got = {v_active, char_row, dot_row};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got act=%0d row=%0d dot=%0d exp act=%0d row=%0d dot=%0d",
               tag, got[9], got[8:5], got[4:0], exp[9], exp[8:5], exp[4:0]);
    end
  endtask

  task automatic set_cfg(input logic [10:0] v);
    {start_pos, size_first, size_rest, ten_rows} = v;
  endtask

  task automatic vsync_pulse();
    vsync_in = 1'b1;
    @(negedge clk); vsync_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic line_tick();
    hs_tick = 1'b1;
    @(negedge clk); hs_tick = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [10:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset, ticks without vsync do nothing
    chk("R1 reset", '0);
    for (int i = 0; i < 5; i++) line_tick();
    chk("R1 ticks before vsync", '0);

    // table walk: R2/R3/R4/R5/R6/R7 on every line
    for (int t = 0; t < 6; t++) begin
      set_cfg(VEC[t]);
      vsync_pulse();
      for (int k = 0; k <= frame_len(VEC[t]) + 3; k++) begin
        chk($sformatf("R2/R3/R4/R5/R6/R7 vec%0d line%0d", t, k), model(k, VEC[t]));
        line_tick();
      end
    end

    // R8: mid-frame change is ignored until the next vsync edge
    a = {6'd1, 2'b01, 2'b00, 1'b1};
    b = {6'd4, 2'b10, 2'b11, 1'b0};
    set_cfg(a);
    vsync_pulse();
    for (int k = 0; k < 60; k++) begin
      if (k == 10) set_cfg(b);
      chk($sformatf("R8 old settings line%0d", k), model(k, a));
      line_tick();
    end
    vsync_pulse();
    for (int k = 0; k < 20; k++) begin
      chk($sformatf("R8 new settings line%0d", k), model(k, b));
      line_tick();
    end

    // R10: no tick, outputs hold
    repeat (6) @(negedge clk);
    chk("R10 hold without tick", model(20, b));

    // R9: restart mid-display
    vsync_pulse();
    chk("R9 restart line0", model(0, b));
    for (int k = 0; k < 12; k++) begin
      line_tick();
      chk($sformatf("R9 after restart line%0d", k + 1), model(k + 1, b));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule